// File: doc/BRIEF.md
# Segment-and-Page Translation Buffer

This block is a small fully associative store of address translations that sits between an address generator and memory. A lookup carries a segment number, a page number and an in-page offset. The segment and page numbers are joined into one key, which is compared against every stored key in the same cycle. One cycle later the block reports either a hit, with the physical address formed from the stored frame number and the unchanged offset, or a miss, with the key that missed.

On a miss, an external table walker fetches the translation from the in-memory tables and hands it back through the refill port. A refill goes into the lowest-numbered empty slot if there is one. When every slot is occupied, it overwrites the slot named by a round-robin pointer. A refill whose key is already stored is dropped, so no key is ever held twice. A flush input empties the whole buffer in one cycle and is meant for context switches.

Top module: `xlat_buffer`

## Requirements
- R1: After reset the buffer holds no translation: `rsp_valid` is low and every lookup reports a miss.
- R2: A lookup accepted at a clock edge (`lk_valid` high, `rf_valid` and `flush` low) gives `rsp_valid` high for exactly one cycle, in the cycle that follows that edge.
- R3: On a hit, `rsp_paddr` is the stored 14-bit frame number in bits [23:10], with the 10-bit lookup offset unchanged in bits [9:0].
- R4: On a miss, `rsp_miss` is high, `rsp_hit` is low, and `rsp_miss_key` equals the lookup key, which has the segment number in bits [23:10] and the page number in bits [9:0].
- R5: After a refill of key K with frame F, a later lookup of K hits and returns F.
- R6: While any slot is empty, a refill fills an empty slot and evicts nothing, so 16 distinct refills after reset or flush are all retained.
- R7: When all 16 slots are full, each refill of a new key evicts the slot at the round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, on every accepted refill. The 17th distinct refill after reset therefore evicts the 1st.
- R8: A refill whose key is already stored has no effect: the stored frame is kept, no slot is used, and the pointer does not move.
- R9: A refill and a lookup in the same cycle: the refill is performed and the lookup is dropped, so no response follows.
- R10: Flush invalidates every entry at the next edge. It takes priority over a refill or a lookup in the same cycle, and both of those are dropped.
- R11: No lookup key ever matches more than one stored entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_seg | input | 14 | Lookup segment number |
| lk_page | input | 10 | Lookup page number |
| lk_ofs | input | 10 | Lookup in-page offset |
| rf_valid | input | 1 | Refill request from the walker |
| rf_key | input | 24 | Refill key {segment, page} |
| rf_frame | input | 14 | Refill physical frame number |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_miss | output | 1 | Response is a miss |
| rsp_paddr | output | 24 | Physical address {frame, offset} |
| rsp_miss_key | output | 24 | Key of the lookup that responded |

## Verification
Each response is due exactly one edge after the lookup is accepted. Storage changes from a refill or a flush take effect at the same edge, so a lookup issued in the next cycle already sees them. The bench drives every input on the falling edge and samples 2 ns after the rising edge. The driver queues the expected response when it issues an accepted lookup, and the monitor pops one entry for each cycle in which `rsp_valid` is seen. Dropped lookups queue nothing, so any response that appears for them shows up as unexpected. For same-cycle collisions the bench also checks directly that `rsp_valid` is low one edge later.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int DEF_SLOTS   = 16;
  localparam int DEF_SEG_W   = 14;
  localparam int DEF_PAGE_W  = 10;
  localparam int DEF_OFS_W   = 10;
  localparam int DEF_FRAME_W = 14;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_HIT  = 2'd1,
    RK_MISS = 2'd2
  } resp_kind_e;

  // advance a round-robin slot pointer with wrap at slot_count
  function automatic int unsigned rr_next(input int unsigned ptr,
                                          input int unsigned slot_count);
    if (ptr + 1 >= slot_count) return 0;
    return ptr + 1;
  endfunction

  // classify a lookup result
  function automatic resp_kind_e classify(input logic fire, input logic hit);
    if (!fire) return RK_NONE;
    return hit ? RK_HIT : RK_MISS;
  endfunction

endpackage

// File: rtl/xlat_tag_array.sv
module xlat_tag_array #(
  parameter int SLOTS   = 16,
  parameter int KEY_W   = 24,
  parameter int FRAME_W = 14,
  localparam int IDX_W  = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [KEY_W-1:0]   lk_key,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [KEY_W-1:0]   wr_key,
  input  logic [FRAME_W-1:0] wr_frame,
  output logic [SLOTS-1:0]   valid_vec,
  output logic [SLOTS-1:0]   lk_match,
  output logic [SLOTS-1:0]   wr_match,
  output logic [FRAME_W-1:0] lk_frame
);

  logic [KEY_W-1:0]   key_q   [SLOTS];
  logic [FRAME_W-1:0] frame_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[s] <= 1'b0;
        key_q[s]     <= '0;
        frame_q[s]   <= '0;
      end else if (flush) begin
        valid_vec[s] <= 1'b0;
      end else if (sel) begin
        valid_vec[s] <= 1'b1;
        key_q[s]     <= wr_key;
        frame_q[s]   <= wr_frame;
      end
    end

    assign lk_match[s] = valid_vec[s] && (key_q[s] == lk_key);
    assign wr_match[s] = valid_vec[s] && (key_q[s] == wr_key);
  end

  // one-hot OR mux of the matching frame
  always_comb begin
    lk_frame = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (lk_match[s]) lk_frame = lk_frame | frame_q[s];
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)) else $error("multiple matching entries"); // R11

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0)) else $error("flush left a valid entry"); // R10

  AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> valid_vec[$past(wr_idx)]) else $error("refilled slot not valid"); // R5

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int SLOTS  = 16,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] valid_vec,
  input  logic             wr_fire,
  output logic [IDX_W-1:0] victim_idx,
  output logic             all_valid
);

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  // lowest-numbered empty slot
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (!valid_vec[s]) begin
        free_idx = IDX_W'(s);
        any_free = 1'b1;
      end
    end
  end

  assign all_valid  = !any_free;
  assign victim_idx = any_free ? free_idx : rr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (wr_fire) begin
      rr_ptr <= IDX_W'(xlat_pkg::rr_next(int'(rr_ptr), SLOTS));
    end
  end

  AST_FREE_SLOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !all_valid) |-> !valid_vec[victim_idx]) else $error("evicted with free slot"); // R6

  AST_PTR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (rr_ptr != $past(rr_ptr))) else $error("pointer did not move"); // R7

  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(rr_ptr)) else $error("pointer moved without refill"); // R8

endmodule

// File: rtl/xlat_resp.sv
module xlat_resp #(
  parameter int OFS_W   = 10,
  parameter int FRAME_W = 14,
  parameter int KEY_W   = 24,
  localparam int PA_W   = FRAME_W + OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_fire,
  input  logic               any_hit,
  input  logic [FRAME_W-1:0] hit_frame,
  input  logic [OFS_W-1:0]   lk_ofs,
  input  logic [KEY_W-1:0]   lk_key,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_miss,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [KEY_W-1:0]   rsp_miss_key
);

  xlat_pkg::resp_kind_e kind_d;
  assign kind_d = xlat_pkg::classify(lk_fire, any_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_paddr    <= '0;
      rsp_miss_key <= '0;
    end else begin
      rsp_valid <= (kind_d != xlat_pkg::RK_NONE);
      rsp_hit   <= (kind_d == xlat_pkg::RK_HIT);
      rsp_miss  <= (kind_d == xlat_pkg::RK_MISS);
      if (lk_fire) begin
        rsp_paddr    <= {(any_hit ? hit_frame : FRAME_W'(0)), lk_ofs};
        rsp_miss_key <= lk_key;
      end
    end
  end

  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_miss)) else $error("hit and miss both or neither"); // R4

  AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> (rsp_paddr[OFS_W-1:0] == $past(lk_ofs))) else $error("offset altered"); // R3

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer #(
  parameter int SLOTS   = xlat_pkg::DEF_SLOTS,
  parameter int SEG_W   = xlat_pkg::DEF_SEG_W,
  parameter int PAGE_W  = xlat_pkg::DEF_PAGE_W,
  parameter int OFS_W   = xlat_pkg::DEF_OFS_W,
  parameter int FRAME_W = xlat_pkg::DEF_FRAME_W,
  localparam int KEY_W  = SEG_W + PAGE_W,
  localparam int PA_W   = FRAME_W + OFS_W,
  localparam int IDX_W  = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               lk_valid,
  input  logic [SEG_W-1:0]   lk_seg,
  input  logic [PAGE_W-1:0]  lk_page,
  input  logic [OFS_W-1:0]   lk_ofs,
  input  logic               rf_valid,
  input  logic [KEY_W-1:0]   rf_key,
  input  logic [FRAME_W-1:0] rf_frame,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_miss,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [KEY_W-1:0]   rsp_miss_key
);

  logic [KEY_W-1:0]   lk_key;
  logic [SLOTS-1:0]   valid_vec;
  logic [SLOTS-1:0]   lk_match;
  logic [SLOTS-1:0]   wr_match;
  logic [FRAME_W-1:0] lk_frame;
  logic [IDX_W-1:0]   victim_idx;
  logic               all_valid;

  // named internal events
  logic rf_dup;
  logic rf_fire;
  logic lk_fire;
  logic any_hit;

  assign lk_key  = {lk_seg, lk_page};
  assign rf_dup  = |wr_match;
  assign rf_fire = rf_valid && !flush && !rf_dup;
  assign lk_fire = lk_valid && !rf_valid && !flush;
  assign any_hit = |lk_match;

  xlat_tag_array #(
    .SLOTS(SLOTS), .KEY_W(KEY_W), .FRAME_W(FRAME_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_key(lk_key),
    .wr_en(rf_fire), .wr_idx(victim_idx), .wr_key(rf_key), .wr_frame(rf_frame),
    .valid_vec(valid_vec), .lk_match(lk_match), .wr_match(wr_match),
    .lk_frame(lk_frame)
  );

  xlat_victim #(.SLOTS(SLOTS)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .wr_fire(rf_fire),
    .victim_idx(victim_idx), .all_valid(all_valid)
  );

  xlat_resp #(
    .OFS_W(OFS_W), .FRAME_W(FRAME_W), .KEY_W(KEY_W)
  ) u_resp (
    .clk(clk), .rst_n(rst_n), .lk_fire(lk_fire), .any_hit(any_hit),
    .hit_frame(lk_frame), .lk_ofs(lk_ofs), .lk_key(lk_key),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_paddr(rsp_paddr), .rsp_miss_key(rsp_miss_key)
  );

  AST_RESP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> rsp_valid) else $error("response missing"); // R2

  AST_RESP_ONLY_ON_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_fire |=> !rsp_valid) else $error("spurious response"); // R2

  AST_REFILL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && lk_valid) |=> !rsp_valid) else $error("lookup not dropped"); // R9

  AST_DUP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && rf_dup && !flush) |=> $stable(valid_vec)) else $error("duplicate refill took effect"); // R8

  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (all_valid && !flush) |=> (valid_vec == '1)) else $error("entry lost without flush"); // R7

endmodule

// File: tb/test_xlat_buffer.sv
`timescale 1ns/1ps
module test_xlat_buffer;

  localparam int SLOTS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic [13:0] lk_seg = '0;
  logic [9:0]  lk_page = '0;
  logic [9:0]  lk_ofs = '0;
  logic        rf_valid = 1'b0;
  logic [23:0] rf_key = '0;
  logic [13:0] rf_frame = '0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [23:0] rsp_paddr, rsp_miss_key;

  always #4 clk = ~clk;

  xlat_buffer i_xlat_buffer (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
    .lk_seg(lk_seg), .lk_page(lk_page), .lk_ofs(lk_ofs),
    .rf_valid(rf_valid), .rf_key(rf_key), .rf_frame(rf_frame),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_paddr(rsp_paddr), .rsp_miss_key(rsp_miss_key)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic        hit;
    logic [23:0] paddr;
    logic [23:0] key;
    string       req;
  } exp_t;
  exp_t sb[$];

  // reference model built from the requirements
  logic        m_valid [SLOTS];
  logic [23:0] m_key   [SLOTS];
  logic [13:0] m_frame [SLOTS];
  int          m_ptr = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] key_of(input int i);
    return {14'(i * 37 + 5), 10'(i * 3 + 1)};
  endfunction

  task automatic model_refill(input logic [23:0] k, input logic [13:0] f);
    int slot;
    for (int s = 0; s < SLOTS; s++) if (m_valid[s] && m_key[s] == k) return;
    slot = -1;
    for (int s = SLOTS - 1; s >= 0; s--) if (!m_valid[s]) slot = s;
    if (slot < 0) slot = m_ptr;
    m_valid[slot] = 1'b1;
    m_key[slot]   = k;
    m_frame[slot] = f;
    m_ptr = (m_ptr + 1) % SLOTS;
  endtask

  task automatic drive(input logic lk, input logic [23:0] lkey, input logic [9:0] ofs,
                       input logic rf, input logic [23:0] rkey, input logic [13:0] rfr,
                       input logic fl, input string req);
    exp_t e;
    @(negedge clk);
    lk_valid = lk; {lk_seg, lk_page} = lkey; lk_ofs = ofs;
    rf_valid = rf; rf_key = rkey; rf_frame = rfr; flush = fl;
    if (lk && !rf && !fl) begin
      e.hit = 1'b0; e.paddr = '0; e.key = lkey; e.req = req;
      for (int s = 0; s < SLOTS; s++)
        if (m_valid[s] && m_key[s] == lkey) begin
          e.hit = 1'b1; e.paddr = {m_frame[s], ofs};
        end
      sb.push_back(e);
    end
    if (fl) begin
      for (int s = 0; s < SLOTS; s++) m_valid[s] = 1'b0;
    end else if (rf) begin
      model_refill(rkey, rfr);
    end
  endtask

  task automatic lookup(input logic [23:0] k, input logic [9:0] ofs, input string req);
    drive(1'b1, k, ofs, 1'b0, '0, '0, 1'b0, req);
  endtask

  task automatic refill(input logic [23:0] k, input logic [13:0] f, input string req);
    drive(1'b0, '0, '0, 1'b1, k, f, 1'b0, req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, '0, 1'b0, '0, '0, 1'b0, "idle");
  endtask

  // monitor: compare each response against the scoreboard
  always @(posedge clk) begin
    #2;
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2", "unexpected response", 32'(rsp_paddr), 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_hit == e.hit && rsp_miss == !e.hit, e.req, "hit flag",
              32'({rsp_hit, rsp_miss}), 32'({e.hit, !e.hit}));
        if (e.hit)
          check(rsp_paddr == e.paddr, e.req, "paddr", 32'(rsp_paddr), 32'(e.paddr));
        else
          check(rsp_miss_key == e.key, e.req, "miss key", 32'(rsp_miss_key), 32'(e.key));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d CHECKS %0d ERRORS %0d", checks, checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SLOTS; s++) m_valid[s] = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(rsp_valid == 1'b0 && rsp_hit == 1'b0, "R1", "reset outputs",
          32'({rsp_valid, rsp_hit}), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // empty after reset
    lookup(key_of(0), 10'h155, "R1_R4");
    lookup(key_of(3), 10'h0AA, "R4");

    // basic refill and hit with offset corners
    refill(key_of(0), 14'h0123, "R5");
    lookup(key_of(0), 10'h3FF, "R3_R5");
    lookup(key_of(0), 10'h000, "R3");

    // fill to 15 entries, then a duplicate refill with another frame
    for (int i = 1; i < 15; i++) refill(key_of(i), 14'(16'h0200 + i), "R6");
    refill(key_of(0), 14'h0777, "R8");
    lookup(key_of(0), 10'h011, "R8");
    refill(key_of(15), 14'h020F, "R6");
    for (int i = 0; i < 16; i++) lookup(key_of(i), 10'(i * 19), "R6_R8");

    // full: round-robin eviction from slot 0
    refill(key_of(16), 14'h0310, "R7");
    lookup(key_of(0), 10'h001, "R7");
    lookup(key_of(16), 10'h002, "R7");
    refill(key_of(17), 14'h0311, "R7");
    lookup(key_of(1), 10'h003, "R7");
    lookup(key_of(2), 10'h004, "R7");
    lookup(key_of(17), 10'h005, "R7");

    // refill and lookup together: lookup dropped
    drive(1'b1, key_of(2), 10'h006, 1'b1, key_of(18), 14'h0312, 1'b0, "R9");
    @(posedge clk); #2;
    check(rsp_valid == 1'b0, "R9", "dropped lookup response", 32'(rsp_valid), 32'h0);
    lookup(key_of(18), 10'h007, "R9");
    lookup(key_of(3), 10'h008, "R9_R7");

    // flush beats refill and lookup in the same cycle
    drive(1'b1, key_of(4), 10'h009, 1'b1, key_of(19), 14'h0313, 1'b1, "R10");
    @(posedge clk); #2;
    check(rsp_valid == 1'b0, "R10", "lookup during flush", 32'(rsp_valid), 32'h0);
    lookup(key_of(19), 10'h00A, "R10");
    lookup(key_of(4), 10'h00B, "R10");
    lookup(key_of(18), 10'h00C, "R10");

    // after flush, slots refill without eviction
    refill(key_of(20), 14'h0ABC, "R6");
    refill(key_of(21), 14'h0ABD, "R6");
    lookup(key_of(20), 10'h2AA, "R5_R6");
    lookup(key_of(21), 10'h155, "R5_R6");
    lookup(key_of(22), 10'h0FF, "R4");

    idle(4);
    check(sb.size() == 0, "R2", "pending responses", 32'(sb.size()), 32'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule